// File: doc/BRIEF.md
# Region Access Guard

The guard sits beside a processor's load/store and fetch path and decides, for every memory access, whether it may proceed or must raise a fault. It holds eight programmable protection regions. Each region has:

- a power-of-two size, with a base aligned to that size;
- an enable bit and an owning process ID;
- per-process read and write grant masks that apply to every process other than the owner;
- a no-execute bit, which makes any instruction fetch into the region fault and halt the process that asked.

Software programs the regions and a control word through a simple register write port.

The check port takes the following, all in one cycle:

- an address;
- an access kind: read, write or fetch;
- the current process ID.

One clock later the guard returns:

- whether the access faults;
- whether the requester must halt;
- whether any region matched, and which one.

Regions may overlap. The highest-numbered enabled region that matches makes the decision. An access that matches nothing follows a background rule set by software.

The first fault is recorded in a sticky log (address, kind, hit, region) until software clears it. A build parameter removes the checking entirely, and that build allows every access.

Top module: `prot_guard`

## Requirements
- R1: After reset every region is disabled, the background rule allows accesses, `rsp_valid` is 0 and `flt_valid` is 0.
- R2: A check presented with `chk_valid`=1 yields exactly one response with `rsp_valid`=1 on the next clock edge; back-to-back checks yield back-to-back responses, and `rsp_valid` is 0 in any cycle after a cycle without a check.
- R3: A region whose size code (attribute bits [4:0]) is k covers 2^(k+1) bytes starting at its base with the low k+1 bits cleared. Codes below 4 act as 4 (32 bytes), and code 31 covers the whole 4 GB space.
- R4: A disabled region (attribute bit 5 clear) never matches. An access that matches no enabled region reports `rsp_hit`=0 and `rsp_region`=0. It faults only when control bit 0 is 0; a value of 1 allows it.
- R5: The owner (attribute bits [10:8]) may read, write and fetch in its region; the only owner access that faults is a fetch into a no-execute region.
- R6: A non-owner process p may read or fetch only if read-grant bit p (attribute bits [23:16]) is set, and may write only if write-grant bit p (attribute bits [31:24]) is set; both masks zero denies every non-owner.
- R7: A fetch (kind 2) into a region with the no-execute bit (attribute bit 6) faults for every process. Any fetch fault asserts `rsp_halt`, and a read or write fault never does.
- R8: When enabled regions overlap, the highest-numbered matching one decides allow or fault and is reported on `rsp_region`.
- R9: The first faulting check is captured in `flt_addr`, `flt_type`, `flt_hit` and `flt_region` with `flt_valid`=1. Later faults leave the log unchanged until a write with `cfg_sel`=3 clears it.
- R10: With `CHECK_EN`=0 every response allows the access with `rsp_hit`=0, and `flt_valid` stays 0.

Register write port: `cfg_sel`=0 writes region `cfg_idx` base, 1 writes its attribute word, 2 writes the control word, 3 clears the fault log. Access kind codes: 0 read, 1 write, 2 fetch, 3 treated as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Target: base, attribute, control, log clear |
| cfg_idx | input | IW | Region number for base/attribute writes |
| cfg_wdata | input | 32 | Write data |
| chk_valid | input | 1 | Access presented for checking |
| chk_addr | input | AW | Access address |
| chk_type | input | 2 | Access kind |
| chk_pid | input | PIDW | Requesting process ID |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 1 | Access must fault |
| rsp_halt | output | 1 | Requester must halt (fetch fault) |
| rsp_hit | output | 1 | Some enabled region matched |
| rsp_region | output | IW | Deciding region |
| flt_valid | output | 1 | Fault log holds an entry |
| flt_addr | output | AW | Logged address |
| flt_type | output | 2 | Logged access kind |
| flt_hit | output | 1 | Logged fault came from a region |
| flt_region | output | IW | Logged region |

## Verification
The bench builds two copies side by side on the same stimulus.

The main copy uses eight regions, 32-bit addresses and 3-bit process IDs. This fills both grant masks exactly, and the full address width lets a size code of 31 cover the whole space, so the 4 GB corner and a fully overlapping region are both reachable.

The second copy has `CHECK_EN`=0. It shows that the disabled build allows every access the main copy rejects and never logs a fault.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_FX = 2'd2;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_ATTR = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_CLR  = 2'd3;

  localparam int ATTR_SIZE = 0;
  localparam int ATTR_EN   = 5;
  localparam int ATTR_NX   = 6;
  localparam int ATTR_OWN  = 8;
  localparam int ATTR_RGR  = 16;
  localparam int ATTR_WGR  = 24;

  localparam logic [4:0] SIZE_MIN = 5'd4;
endpackage

// File: rtl/prot_region_slot.sv
module prot_region_slot
  import prot_pkg::*;
#(
  parameter int AW   = 32,
  parameter int PIDW = 3,
  localparam int NPID = 1 << PIDW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_base,
  input  logic            wr_attr,
  input  logic [31:0]     wdata,
  input  logic [AW-1:0]   chk_addr,
  input  logic [1:0]      chk_type,
  input  logic [PIDW-1:0] chk_pid,
  output logic            hit,
  output logic            allow
);
  logic [AW-1:0]   base_q;
  logic [4:0]      size_q;
  logic            en_q, nx_q;
  logic [PIDW-1:0] own_q;
  logic [NPID-1:0] rgr_q, wgr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      size_q <= SIZE_MIN;
      en_q   <= 1'b0;
      nx_q   <= 1'b0;
      own_q  <= '0;
      rgr_q  <= '0;
      wgr_q  <= '0;
    end else begin
      if (wr_base) base_q <= wdata[AW-1:0];
      if (wr_attr) begin
        size_q <= wdata[ATTR_SIZE +: 5];
        en_q   <= wdata[ATTR_EN];
        nx_q   <= wdata[ATTR_NX];
        own_q  <= wdata[ATTR_OWN +: PIDW];
        rgr_q  <= wdata[ATTR_RGR +: NPID];
        wgr_q  <= wdata[ATTR_WGR +: NPID];
      end
    end
  end

  logic unused_attr_bits;
  assign unused_attr_bits = ^{wdata[7], wdata[15:11]};

  // offset bits inside the region are ignored in the compare
  logic [4:0]    size_eff;
  logic [AW-1:0] span;
  always_comb begin
    size_eff = (size_q < SIZE_MIN) ? SIZE_MIN : size_q;
    for (int i = 0; i < AW; i++) span[i] = (i <= int'(size_eff));
  end

  logic is_owner;
  assign is_owner = (chk_pid == own_q);
  assign hit = en_q && (((chk_addr ^ base_q) & ~span) == '0);

  always_comb begin
    case (chk_type)
      ACC_FX:  allow = !nx_q && (is_owner || rgr_q[chk_pid]);
      ACC_WR:  allow = is_owner || wgr_q[chk_pid];
      default: allow = is_owner || rgr_q[chk_pid];
    endcase
  end

  // a no-execute region never allows a fetch, whoever asks
  assert_nx_fetch_R7: assert property (@(posedge clk) disable iff (rst)
    (nx_q && chk_type == ACC_FX) |-> !allow);
endmodule

// File: rtl/prot_region_pick.sv
module prot_region_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  hits,
  input  logic [N-1:0]  allows,
  output logic          any_hit,
  output logic [IW-1:0] idx,
  output logic          allow
);
  always_comb begin
    any_hit = 1'b0;
    idx     = '0;
    allow   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hits[i]) begin
        any_hit = 1'b1;
        idx     = IW'(i);
        allow   = allows[i];
      end
    end
  end

  // chosen region matches and no higher one does
  assert_pick_highest_R8: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> (hits[idx] && ((hits >> idx) >> 1) == '0));
  assert_pick_none_R4: assert property (@(posedge clk) disable iff (rst)
    (hits == '0) |-> (!any_hit && idx == '0));
endmodule

// File: rtl/prot_fault_log.sv
module prot_fault_log #(
  parameter int AW = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          capture,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    typ,
  input  logic          hit,
  input  logic [IW-1:0] region,
  output logic          valid,
  output logic [AW-1:0] log_addr,
  output logic [1:0]    log_type,
  output logic          log_hit,
  output logic [IW-1:0] log_region
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid      <= 1'b0;
      log_addr   <= '0;
      log_type   <= '0;
      log_hit    <= 1'b0;
      log_region <= '0;
    end else begin
      if (clr) valid <= 1'b0;
      if (capture && (!valid || clr)) begin
        valid      <= 1'b1;
        log_addr   <= addr;
        log_type   <= typ;
        log_hit    <= hit;
        log_region <= region;
      end
    end
  end

  assert_log_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && !clr) |=> (valid && $stable(log_addr) && $stable(log_region)
                         && $stable(log_type)));
endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_pkg::*;
#(
  parameter int NREG     = 8,
  parameter int AW       = 32,
  parameter int PIDW     = 3,
  parameter bit CHECK_EN = 1'b1,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [31:0]     cfg_wdata,
  input  logic            chk_valid,
  input  logic [AW-1:0]   chk_addr,
  input  logic [1:0]      chk_type,
  input  logic [PIDW-1:0] chk_pid,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic            rsp_halt,
  output logic            rsp_hit,
  output logic [IW-1:0]   rsp_region,
  output logic            flt_valid,
  output logic [AW-1:0]   flt_addr,
  output logic [1:0]      flt_type,
  output logic            flt_hit,
  output logic [IW-1:0]   flt_region
);
  logic          fault_c, hit_c;
  logic [IW-1:0] region_c;

  generate
    if (CHECK_EN) begin : g_on
      logic [NREG-1:0] hits, allows;
      logic            bg_allow, sel_allow;

      always_ff @(posedge clk) begin
        if (rst) bg_allow <= 1'b1;
        else if (cfg_we && cfg_sel == SEL_CTRL) bg_allow <= cfg_wdata[0];
      end

      for (genvar r = 0; r < NREG; r++) begin : g_slot
        prot_region_slot #(.AW(AW), .PIDW(PIDW)) u_slot (
          .clk      (clk),
          .rst      (rst),
          .wr_base  (cfg_we && cfg_sel == SEL_BASE && cfg_idx == IW'(r)),
          .wr_attr  (cfg_we && cfg_sel == SEL_ATTR && cfg_idx == IW'(r)),
          .wdata    (cfg_wdata),
          .chk_addr (chk_addr),
          .chk_type (chk_type),
          .chk_pid  (chk_pid),
          .hit      (hits[r]),
          .allow    (allows[r])
        );
      end

      prot_region_pick #(.N(NREG)) u_pick (
        .clk     (clk),
        .rst     (rst),
        .hits    (hits),
        .allows  (allows),
        .any_hit (hit_c),
        .idx     (region_c),
        .allow   (sel_allow)
      );

      assign fault_c = hit_c ? !sel_allow : !bg_allow;
    end else begin : g_off
      logic unused_cfg;
      assign unused_cfg = ^{cfg_idx, cfg_wdata, chk_pid};
      assign fault_c  = 1'b0;
      assign hit_c    = 1'b0;
      assign region_c = '0;

      assert_off_allows_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!rsp_fault && !rsp_hit));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_halt   <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
    end else begin
      rsp_valid <= chk_valid;
      if (chk_valid) begin
        rsp_fault  <= fault_c;
        rsp_halt   <= fault_c && (chk_type == ACC_FX);
        rsp_hit    <= hit_c;
        rsp_region <= region_c;
      end else begin
        rsp_fault  <= 1'b0;
        rsp_halt   <= 1'b0;
        rsp_hit    <= 1'b0;
        rsp_region <= '0;
      end
    end
  end

  prot_fault_log #(.AW(AW), .IW(IW)) u_log (
    .clk        (clk),
    .rst        (rst),
    .clr        (cfg_we && cfg_sel == SEL_CLR),
    .capture    (chk_valid && fault_c),
    .addr       (chk_addr),
    .typ        (chk_type),
    .hit        (hit_c),
    .region     (region_c),
    .valid      (flt_valid),
    .log_addr   (flt_addr),
    .log_type   (flt_type),
    .log_hit    (flt_hit),
    .log_region (flt_region)
  );

  assert_rsp_next_R2: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !rsp_valid);
  assert_halt_fetch_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_halt |-> (rsp_fault && $past(chk_type) == ACC_FX));
  assert_miss_region_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_region == '0));
  assert_fault_logged_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> flt_valid);
endmodule

// File: tb/sim_prot_guard.sv
module sim_prot_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        chk_valid = 1'b0;
  logic [31:0] chk_addr = '0;
  logic [1:0]  chk_type = '0;
  logic [2:0]  chk_pid = '0;

  logic        rsp_valid, rsp_fault, rsp_halt, rsp_hit, flt_valid, flt_hit;
  logic [2:0]  rsp_region, flt_region;
  logic [31:0] flt_addr;
  logic [1:0]  flt_type;
  logic        v1_valid, v1_fault, v1_halt, v1_hit, v1_fv, v1_fh;
  logic [2:0]  v1_region, v1_fr;
  logic [31:0] v1_fa;
  logic [1:0]  v1_ft;

  prot_guard #(.NREG(8), .AW(32), .PIDW(3), .CHECK_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .chk_valid(chk_valid), .chk_addr(chk_addr),
    .chk_type(chk_type), .chk_pid(chk_pid), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_halt(rsp_halt), .rsp_hit(rsp_hit),
    .rsp_region(rsp_region), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .flt_type(flt_type), .flt_hit(flt_hit), .flt_region(flt_region));

  prot_guard #(.NREG(8), .AW(32), .PIDW(3), .CHECK_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .chk_valid(chk_valid), .chk_addr(chk_addr),
    .chk_type(chk_type), .chk_pid(chk_pid), .rsp_valid(v1_valid),
    .rsp_fault(v1_fault), .rsp_halt(v1_halt), .rsp_hit(v1_hit),
    .rsp_region(v1_region), .flt_valid(v1_fv), .flt_addr(v1_fa),
    .flt_type(v1_ft), .flt_hit(v1_fh), .flt_region(v1_fr));

  typedef struct {
    logic       fault;
    logic       halt;
    logic       hit;
    logic [2:0] rg;
    string      tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0, issued = 0, v1_seen = 0, v1_bad = 0;
  bit done = 1'b0;

  task automatic expect_eq(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] attr(logic [4:0] sz, logic en, logic nx,
                                       logic [2:0] own, logic [7:0] rg, logic [7:0] wg);
    return {wg, rg, 5'b0, own, 1'b0, nx, en, sz};
  endfunction

  task automatic wr(logic [1:0] sel, logic [2:0] idx, logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk(logic [31:0] a, logic [1:0] t, logic [2:0] p,
                     logic ef, logic eh, logic ehit, logic [2:0] erg, string tag);
    exp_t e;
    e.fault = ef; e.halt = eh; e.hit = ehit; e.rg = erg; e.tag = tag;
    chk_valid = 1'b1; chk_addr = a; chk_type = t; chk_pid = p;
    sb.push_back(e);
    issued++;
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        expect_eq("R2", "unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        expect_eq(e.tag, "fault/halt/hit/region",
                  {60'd0, rsp_fault, rsp_halt, rsp_hit, 1'b0} << 3 | 64'(rsp_region),
                  {60'd0, e.fault, e.halt, e.hit, 1'b0} << 3 | 64'(e.rg));
      end
    end
    if (!rst && v1_valid) begin
      v1_seen++;
      if (v1_fault || v1_hit || v1_halt) v1_bad++;
    end
  end

  task automatic log_is(string tag, logic v, logic [31:0] a, logic [1:0] t,
                        logic h, logic [2:0] r);
    expect_eq(tag, "flt_valid", 64'(flt_valid), 64'(v));
    if (v) begin
      expect_eq(tag, "flt_addr", 64'(flt_addr), 64'(a));
      expect_eq(tag, "flt_type", 64'(flt_type), 64'(t));
      expect_eq(tag, "flt_hit", 64'(flt_hit), 64'(h));
      expect_eq(tag, "flt_region", 64'(flt_region), 64'(r));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    expect_eq("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    expect_eq("R1", "flt_valid", 64'(flt_valid), 64'd0);
    chk(32'h1000, 2'd0, 3'd0, 0, 0, 0, 3'd0, "R1 background allow");

    // region 0: 256 B at 0x1000, owner 2, pid3 may read only
    wr(2'd0, 3'd0, 32'h1000);
    wr(2'd1, 3'd0, attr(5'd7, 1, 0, 3'd2, 8'h08, 8'h00));
    chk(32'h1010, 2'd1, 3'd2, 0, 0, 1, 3'd0, "R5 owner write");
    chk(32'h10FF, 2'd0, 3'd3, 0, 0, 1, 3'd0, "R6 granted read");
    chk(32'h1004, 2'd1, 3'd3, 1, 0, 1, 3'd0, "R6 read-only write");
    chk(32'h1020, 2'd0, 3'd5, 1, 0, 1, 3'd0, "R6 ungranted read");
    chk(32'h1100, 2'd0, 3'd5, 0, 0, 0, 3'd0, "R3 past end");
    chk(32'h0FFF, 2'd0, 3'd5, 0, 0, 0, 3'd0, "R3 below base");
    idle(2);
    log_is("R9 first fault", 1, 32'h1004, 2'd1, 1, 3'd0);

    // region 1: 32 B at unaligned 0x1085 -> 0x1080, no-execute, open grants
    wr(2'd0, 3'd1, 32'h1085);
    wr(2'd1, 3'd1, attr(5'd4, 1, 1, 3'd2, 8'hFF, 8'hFF));
    chk(32'h1090, 2'd2, 3'd2, 1, 1, 1, 3'd1, "R7 owner fetch no-exec");
    chk(32'h1088, 2'd1, 3'd3, 0, 0, 1, 3'd1, "R8 overlap higher wins");
    chk(32'h10A0, 2'd1, 3'd3, 1, 0, 1, 3'd0, "R3 aligned 32B end");
    chk(32'h1084, 2'd0, 3'd2, 0, 0, 1, 3'd1, "R5 owner read no-exec");
    idle(2);
    log_is("R9 sticky", 1, 32'h1004, 2'd1, 1, 3'd0);
    wr(2'd3, 3'd0, 32'h0);
    log_is("R9 cleared", 0, 32'h0, 2'd0, 0, 3'd0);

    wr(2'd1, 3'd1, attr(5'd4, 0, 1, 3'd2, 8'hFF, 8'hFF));
    chk(32'h1088, 2'd1, 3'd3, 1, 0, 1, 3'd0, "R4 disabled no match");
    idle(2);
    log_is("R9 recapture", 1, 32'h1088, 2'd1, 1, 3'd0);

    wr(2'd2, 3'd0, 32'h0);
    chk(32'h8000, 2'd0, 3'd0, 1, 0, 0, 3'd0, "R4 background fault");

    // region 7: whole space, owner 1, no grants
    wr(2'd0, 3'd7, 32'h0);
    wr(2'd1, 3'd7, attr(5'd31, 1, 0, 3'd1, 8'h00, 8'h00));
    chk(32'hFFFF_FFF0, 2'd2, 3'd1, 0, 0, 1, 3'd7, "R3 4GB owner fetch");
    chk(32'h1000, 2'd0, 3'd3, 1, 0, 1, 3'd7, "R8 top region denies");
    wr(2'd1, 3'd7, attr(5'd31, 0, 0, 3'd1, 8'h00, 8'h00));
    chk(32'h1040, 2'd2, 3'd3, 0, 0, 1, 3'd0, "R6 foreign fetch granted");
    chk(32'h1040, 2'd2, 3'd4, 1, 1, 1, 3'd0, "R7 foreign fetch halt");

    // region 2: size code 2 acts as 32 B
    wr(2'd0, 3'd2, 32'h2000);
    wr(2'd1, 3'd2, attr(5'd2, 1, 0, 3'd0, 8'h00, 8'h00));
    chk(32'h201F, 2'd0, 3'd0, 0, 0, 1, 3'd2, "R3 min size last byte");
    chk(32'h2020, 2'd0, 3'd0, 1, 0, 0, 3'd0, "R3 min size past end");
    idle(3);

    log_is("R9 held", 1, 32'h1088, 2'd1, 1, 3'd0);
    expect_eq("R2", "pending expectations", 64'(sb.size()), 64'd0);
    expect_eq("R10", "disabled copy responses", 64'(v1_seen), 64'(issued));
    expect_eq("R10", "disabled copy fault/hit", 64'(v1_bad), 64'd0);
    expect_eq("R10", "disabled copy log", 64'(v1_fv), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule